// File: doc/BRIEF.md
# Supply window qualification controller

This block decides when an incoming supply may be handed to protected loads through an external switch. It watches the supply level in one of two forms, picked by a parameter. The first is a stream of ADC codes, to which it applies its own trip points and hysteresis. The second is a pair of fault flags from external comparators, which it resynchronises. A supply counts as good only while it lies strictly inside the window between the undervoltage and overvoltage trip points.

The controller has two states, standby and on. Both outputs are high in standby and low in the on state: `gate_off_o` holds the switch open, and `pgood_n_o` reports a fault. To leave standby, the supply must stay inside the window without a break for a debounce time of `DEB_MS` milliseconds, counted by a millisecond prescaler. If the supply leaves the window during that time, the count clears, and the next entry into the window restarts the full interval. Once the controller is on, any excursion out of the window drops it back to standby without filtering. Both outputs change in the same clock cycle.

The sample stream uses valid/ready. In code mode `samp_ready_o` is tied high: the block takes one sample per cycle, never applies back-pressure, and holds the last accepted sample's verdict until a new sample arrives. In comparator mode `samp_ready_o` is low, so no sample is ever taken.

Top module: `supply_window_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `gate_off_o` and `pgood_n_o` are both 1 (standby). The window is treated as undervoltage until a good sample clears it.
- R2: In code mode, an accepted code greater than `OV_TRIP` sets the overvoltage fault. A code equal to `OV_TRIP` does not set it. Once set, the fault clears only on an accepted code at or below `OV_TRIP - OV_HYST`.
- R3: In code mode, an accepted code below `UV_TRIP` sets the undervoltage fault. A code equal to `UV_TRIP` does not set it. Once set, the fault clears only on an accepted code at or above `UV_TRIP + UV_HYST`.
- R4: The controller enters the on state, with both outputs 0, exactly `DEB_MS*CLK_KHZ` cycles after the clock edge at which both fault flags read clear. In code mode that edge is the one accepting the sample, so the outputs change `DEB_MS*CLK_KHZ + 1` edges after that sample. No earlier cycle shows the on state.
- R5: A fault during the debounce interval clears the timer. The next return to the window must again last the full `DEB_MS*CLK_KHZ` cycles before the outputs go low.
- R6: A fault flag takes both outputs to 1 at the next clock edge, with no filtering. In code mode that is two edges after the faulting sample is accepted.
- R7: `gate_off_o` and `pgood_n_o` are equal in every cycle.
- R8: A code presented with `samp_valid_i` low has no effect on the outputs.
- R9: In comparator mode (`SENSE_ADC = 0`), `uv_cmp_i` and `ov_cmp_i` (1 = fault) each pass through two flops before use. A fault flag drives the outputs high one edge after it leaves the synchroniser. When both flags have read 0 for the full debounce interval, the controller enters the on state.
- R10: `samp_ready_o` is 1 in code mode and 0 in comparator mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_valid_i | input | 1 | Sample valid (code mode) |
| samp_ready_o | output | 1 | Sample ready: 1 in code mode, 0 in comparator mode |
| samp_code_i | input | CODE_W | Sampled supply code |
| uv_cmp_i | input | 1 | Asynchronous undervoltage comparator flag, 1 = fault (comparator mode) |
| ov_cmp_i | input | 1 | Asynchronous overvoltage comparator flag, 1 = fault (comparator mode) |
| gate_off_o | output | 1 | 1 = switch off (standby), 0 = switch on |
| pgood_n_o | output | 1 | 1 = supply fault (standby), 0 = supply good |

## Verification
The bench builds the block with `CLK_KHZ = 4` and `DEB_MS = 12`, which gives a 48-cycle debounce. At that length the edge just before the switch-on cycle and the edge that reaches it can be checked directly, and an aborted debounce can be timed against a restarted one. The trip points are 700 and 240, with hysteresis widths of 10 and 8. These put the codes equal to each trip point, one step past it, and inside each hysteresis band within a handful of samples. A second instance in comparator mode exposes the two-flop synchroniser latency on both flags.

// File: rtl/swq_pkg.sv
package swq_pkg;
  typedef enum logic {
    SWQ_STBY = 1'b0,
    SWQ_ON   = 1'b1
  } swq_state_e;
endpackage

// File: rtl/swq_sync2.sv
// Two-flop synchroniser with a per-bit reset value.
module swq_sync2 #(
  parameter int unsigned      W       = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      hold_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      hold_q <= meta_q;
    end
  end

  assign q_o = hold_q;
endmodule

// File: rtl/swq_adc_window.sv
// Registered window comparator with hysteresis on both trip points.
module swq_adc_window #(
  parameter int unsigned CODE_W  = 10,
  parameter int unsigned OV_TRIP = 718,
  parameter int unsigned OV_HYST = 7,
  parameter int unsigned UV_TRIP = 244,
  parameter int unsigned UV_HYST = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              uv_o,
  output logic              ov_o
);
  localparam logic [CODE_W-1:0] OV_SET = CODE_W'(OV_TRIP);
  localparam logic [CODE_W-1:0] OV_CLR = CODE_W'(OV_TRIP - OV_HYST);
  localparam logic [CODE_W-1:0] UV_SET = CODE_W'(UV_TRIP);
  localparam logic [CODE_W-1:0] UV_CLR = CODE_W'(UV_TRIP + UV_HYST);

  logic uv_q, ov_q;
  logic uv_d, ov_d;

  always_comb begin
    uv_d = uv_q;
    ov_d = ov_q;
    if (take_i) begin
      // overvoltage: trips on a rising code, releases below the band
      if (code_i > OV_SET)       ov_d = 1'b1;
      else if (code_i <= OV_CLR) ov_d = 1'b0;
      // undervoltage: trips on a falling code, releases above the band
      if (code_i < UV_SET)       uv_d = 1'b1;
      else if (code_i >= UV_CLR) uv_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uv_q <= 1'b1;   // unknown supply counts as too low
      ov_q <= 1'b0;
    end else begin
      uv_q <= uv_d;
      ov_q <= ov_d;
    end
  end

  assign uv_o = uv_q;
  assign ov_o = ov_q;
endmodule

// File: rtl/swq_debounce.sv
// Millisecond prescaler plus millisecond counter; clears whenever run_i drops.
module swq_debounce #(
  parameter int unsigned CYC_PER_MS = 250000,
  parameter int unsigned DEB_MS     = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam int unsigned MW = $clog2(DEB_MS + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_MS - 1);
  localparam logic [MW-1:0] MS_LAST  = MW'(DEB_MS - 1);

  logic [PW-1:0] pre_q;
  logic [MW-1:0] ms_q;
  logic          ms_tick;

  assign ms_tick  = (pre_q == PRE_LAST);
  assign expire_o = run_i && ms_tick && (ms_q == MS_LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (ms_tick) begin
      pre_q <= '0;
      ms_q  <= ms_q + MW'(1);
    end else begin
      pre_q <= pre_q + PW'(1);
    end
  end
endmodule

// File: rtl/swq_fsm.sv
// Standby / on controller with both outputs registered from the next state.
module swq_fsm
  import swq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fault_i,
  input  logic expire_i,
  output logic run_o,
  output logic gate_off_o,
  output logic pgood_n_o
);
  swq_state_e st_q, st_d;
  logic gate_q, pg_n_q;

  always_comb begin
    st_d = st_q;
    if (fault_i)                                st_d = SWQ_STBY;
    else if (st_q == SWQ_STBY && expire_i)      st_d = SWQ_ON;
  end

  assign run_o = !fault_i && (st_q == SWQ_STBY);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SWQ_STBY;
      gate_q <= 1'b1;
      pg_n_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      gate_q <= (st_d == SWQ_STBY);
      pg_n_q <= (st_d == SWQ_STBY);
    end
  end

  assign gate_off_o = gate_q;
  assign pgood_n_o  = pg_n_q;
endmodule

// File: rtl/supply_window_ctrl.sv
// Supply window qualification controller, top level.
// Codes are in ADC LSBs; defaults assume 10 mV per LSB.
module supply_window_ctrl #(
  parameter int unsigned SENSE_ADC = 1,
  parameter int unsigned CODE_W    = 10,
  parameter int unsigned OV_TRIP   = 718,
  parameter int unsigned OV_HYST   = 7,
  parameter int unsigned UV_TRIP   = 244,
  parameter int unsigned UV_HYST   = 2,
  parameter int unsigned CLK_KHZ   = 250000,
  parameter int unsigned DEB_MS    = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              samp_valid_i,
  output logic              samp_ready_o,
  input  logic [CODE_W-1:0] samp_code_i,
  input  logic              uv_cmp_i,
  input  logic              ov_cmp_i,
  output logic              gate_off_o,
  output logic              pgood_n_o
);
  logic uv_flag, ov_flag;
  logic fault_w;
  logic run_w;
  logic tmr_expire;
  logic unused_in;

  generate
    if (SENSE_ADC != 0) begin : g_code
      assign samp_ready_o = 1'b1;
      assign unused_in    = uv_cmp_i ^ ov_cmp_i;
      swq_adc_window #(
        .CODE_W (CODE_W),
        .OV_TRIP(OV_TRIP),
        .OV_HYST(OV_HYST),
        .UV_TRIP(UV_TRIP),
        .UV_HYST(UV_HYST)
      ) u_win (
        .clk   (clk),
        .rst   (rst),
        .take_i(samp_valid_i && samp_ready_o),
        .code_i(samp_code_i),
        .uv_o  (uv_flag),
        .ov_o  (ov_flag)
      );
    end else begin : g_cmp
      logic [1:0] sync_q;
      assign samp_ready_o = 1'b0;
      assign unused_in    = samp_valid_i ^ (^samp_code_i);
      swq_sync2 #(
        .W      (2),
        .RST_VAL(2'b10)
      ) u_sync (
        .clk(clk),
        .rst(rst),
        .d_i({uv_cmp_i, ov_cmp_i}),
        .q_o(sync_q)
      );
      assign uv_flag = sync_q[1];
      assign ov_flag = sync_q[0];
    end
  endgenerate

  assign fault_w = uv_flag | ov_flag;

  swq_debounce #(
    .CYC_PER_MS(CLK_KHZ),
    .DEB_MS    (DEB_MS)
  ) u_deb (
    .clk     (clk),
    .rst     (rst),
    .run_i   (run_w),
    .expire_o(tmr_expire)
  );

  swq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .fault_i   (fault_w),
    .expire_i  (tmr_expire),
    .run_o     (run_w),
    .gate_off_o(gate_off_o),
    .pgood_n_o (pgood_n_o)
  );
endmodule

// File: rtl/swq_checker.sv
module swq_checker #(
  parameter int unsigned SENSE_ADC = 1,
  parameter int unsigned CODE_W    = 10,
  parameter int unsigned OV_TRIP   = 718,
  parameter int unsigned UV_TRIP   = 244
) (
  input logic              clk,
  input logic              rst,
  input logic              samp_valid_i,
  input logic [CODE_W-1:0] samp_code_i,
  input logic              uv_flag,
  input logic              ov_flag,
  input logic              fault_w,
  input logic              tmr_expire,
  input logic              gate_off_o,
  input logic              pgood_n_o
);
  localparam logic [CODE_W-1:0] OV_C = CODE_W'(OV_TRIP);
  localparam logic [CODE_W-1:0] UV_C = CODE_W'(UV_TRIP);
  localparam logic              IS_CODE = (SENSE_ADC != 0);

  a_r1_reset_standby: assert property (@(posedge clk)
    rst |=> (gate_off_o && pgood_n_o));

  a_r2_ov_sets: assert property (@(posedge clk) disable iff (rst)
    (IS_CODE && samp_valid_i && samp_code_i > OV_C) |=> ov_flag);

  a_r3_uv_sets: assert property (@(posedge clk) disable iff (rst)
    (IS_CODE && samp_valid_i && samp_code_i < UV_C) |=> uv_flag);

  a_r4_on_after_expiry: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_off_o) |-> ($past(tmr_expire) && !$past(fault_w)));

  a_r6_fault_drops: assert property (@(posedge clk) disable iff (rst)
    fault_w |=> (gate_off_o && pgood_n_o));

  a_r7_outputs_paired: assert property (@(posedge clk) disable iff (rst)
    gate_off_o == pgood_n_o);
endmodule

bind supply_window_ctrl swq_checker #(
  .SENSE_ADC(SENSE_ADC),
  .CODE_W   (CODE_W),
  .OV_TRIP  (OV_TRIP),
  .UV_TRIP  (UV_TRIP)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .samp_valid_i(samp_valid_i),
  .samp_code_i (samp_code_i),
  .uv_flag     (uv_flag),
  .ov_flag     (ov_flag),
  .fault_w     (fault_w),
  .tmr_expire  (tmr_expire),
  .gate_off_o  (gate_off_o),
  .pgood_n_o   (pgood_n_o)
);

// File: tb/sim_supply_window_ctrl.sv
`timescale 1ns/1ps
module sim_supply_window_ctrl;
  localparam int CODE_W = 10;
  localparam int KHZ    = 4;
  localparam int DMS    = 12;
  localparam int T      = KHZ * DMS;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic rst = 1'b1;
  logic samp_valid = 1'b0;
  logic [CODE_W-1:0] samp_code = '0;
  logic uvc = 1'b1, ovc = 1'b0;
  logic rdy0, gate0, pg0;
  logic rdy1, gate1, pg1;

  supply_window_ctrl #(
    .SENSE_ADC(1), .CODE_W(CODE_W), .OV_TRIP(700), .OV_HYST(10),
    .UV_TRIP(240), .UV_HYST(8), .CLK_KHZ(KHZ), .DEB_MS(DMS)
  ) u0 (
    .clk(clk), .rst(rst), .samp_valid_i(samp_valid), .samp_ready_o(rdy0),
    .samp_code_i(samp_code), .uv_cmp_i(1'b0), .ov_cmp_i(1'b0),
    .gate_off_o(gate0), .pgood_n_o(pg0)
  );

  supply_window_ctrl #(
    .SENSE_ADC(0), .CODE_W(CODE_W), .OV_TRIP(700), .OV_HYST(10),
    .UV_TRIP(240), .UV_HYST(8), .CLK_KHZ(KHZ), .DEB_MS(DMS)
  ) u1 (
    .clk(clk), .rst(rst), .samp_valid_i(1'b0), .samp_ready_o(rdy1),
    .samp_code_i('0), .uv_cmp_i(uvc), .ov_cmp_i(ovc),
    .gate_off_o(gate1), .pgood_n_o(pg1)
  );

  typedef struct {
    int    at;
    int    unit;
    bit    off;
    string tag;
  } exp_t;
  exp_t q[$];

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // driver side: queue an expected output level for a future cycle, kept sorted
  task automatic expect_at(input int at, input int unit, input bit off, input string tag);
    exp_t e;
    int idx;
    e.at = at; e.unit = unit; e.off = off; e.tag = tag;
    idx = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].at > at) begin idx = i; break; end
    end
    q.insert(idx, e);
  endtask

  // monitor side: pop and compare at the falling edge
  always @(negedge clk) begin
    exp_t e;
    logic g, f;
    while (q.size() > 0 && q[0].at <= cyc) begin
      e = q.pop_front();
      total++;
      g = (e.unit == 1) ? gate1 : gate0;
      f = (e.unit == 1) ? pg1 : pg0;
      if (e.at != cyc) begin
        bad++;
        $display("FAIL %s: sample at cycle %0d missed (now %0d), got %b/%b expected %b",
                 e.tag, e.at, cyc, g, f, e.off);
      end else if (g !== e.off || f !== e.off) begin
        bad++;
        $display("FAIL %s @%0d unit%0d: gate_off=%b pgood_n=%b expected %b (R7 pair)",
                 e.tag, cyc, e.unit, g, f, e.off);
      end
    end
  end

  task automatic check_bit(input logic got, input logic exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // call only just after a falling edge
  task automatic send(input int code, output int c0);
    samp_valid = 1'b1;
    samp_code  = CODE_W'(code);
    c0 = cyc;
    @(negedge clk);
    samp_valid = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run hung, got cycle %0d expected finish", cyc);
    finish_run();
  end

  initial begin
    int c0, c1, c2, c3, c;
    repeat (3) @(negedge clk);
    check_bit(rdy0, 1'b1, "R10 ready code mode");
    check_bit(rdy1, 1'b0, "R10 ready cmp mode");
    rst = 1'b0;
    expect_at(cyc + 1, 0, 1, "R1 reset u0");
    expect_at(cyc + 1, 1, 1, "R1 reset u1");
    repeat (2) @(negedge clk);

    // R4: full debounce from a good sample
    send(500, c0);
    expect_at(c0 + 2, 0, 1, "R4 early");
    expect_at(c0 + T, 0, 1, "R4 last off cycle");
    expect_at(c0 + T + 1, 0, 0, "R4 on");
    wait_until(c0 + T + 3);

    // R2 / R6: overvoltage from on state, two-edge latency
    send(705, c0);
    expect_at(c0 + 1, 0, 0, "R6 still on");
    expect_at(c0 + 2, 0, 1, "R6 R2 ov trip");
    wait_until(c0 + 4);
    send(695, c0);
    expect_at(c0 + T + 4, 0, 1, "R2 hysteresis hold");
    wait_until(c0 + T + 5);
    send(690, c0);
    expect_at(c0 + T, 0, 1, "R2 release wait");
    expect_at(c0 + T + 1, 0, 0, "R2 release on");
    wait_until(c0 + T + 3);

    // R2 boundary: equal to trip is not a fault
    send(700, c0);
    expect_at(c0 + 2, 0, 0, "R2 at trip");
    expect_at(c0 + 5, 0, 0, "R2 at trip later");
    wait_until(c0 + 6);
    send(701, c0);
    expect_at(c0 + 2, 0, 1, "R2 one above trip");
    wait_until(c0 + 3);
    send(500, c0);
    expect_at(c0 + T + 1, 0, 0, "R4 back on");
    wait_until(c0 + T + 3);

    // R3 boundary and hysteresis
    send(240, c0);
    expect_at(c0 + 3, 0, 0, "R3 at trip");
    wait_until(c0 + 4);
    send(239, c0);
    expect_at(c0 + 2, 0, 1, "R3 below trip");
    wait_until(c0 + 3);
    send(245, c0);
    expect_at(c0 + T + 4, 0, 1, "R3 hysteresis hold");
    wait_until(c0 + T + 5);

    // R5: aborted debounce restarts from zero
    send(300, c1);
    wait_until(c1 + 20);
    send(100, c2);
    expect_at(c1 + T + 1, 0, 1, "R5 no resume");
    wait_until(c2 + 5);
    send(300, c3);
    expect_at(c3 + T, 0, 1, "R5 full interval");
    expect_at(c3 + T + 1, 0, 0, "R5 restart on");
    wait_until(c3 + T + 3);

    // R8: code without valid is ignored
    samp_code = CODE_W'(900);
    samp_valid = 1'b0;
    c = cyc;
    for (int k = 1; k <= 10; k++) expect_at(c + k, 0, 0, "R8 no valid");
    wait_until(c + 11);

    // R1: synchronous reset from on state
    rst = 1'b1;
    expect_at(cyc + 1, 0, 1, "R1 sync reset");
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    send(500, c0);
    expect_at(c0 + T + 1, 0, 0, "R4 after reset");
    wait_until(c0 + T + 3);

    // R9: comparator mode, two-flop synchroniser
    uvc = 1'b0;
    c = cyc;
    expect_at(c + T + 1, 1, 1, "R9 debounce pending");
    expect_at(c + T + 2, 1, 0, "R9 on");
    wait_until(c + T + 4);
    ovc = 1'b1;
    c = cyc;
    expect_at(c + 2, 1, 0, "R9 sync latency");
    expect_at(c + 3, 1, 1, "R9 ov off");
    wait_until(c + 5);
    ovc = 1'b0;

    wait (q.size() == 0);
    @(negedge clk);
    finish_run();
  end
endmodule